// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block ends the bus cycles of a master that runs acknowledge-terminated transfers. Once a cycle is launched, the block drives the address strobe and watches three already-synchronized inputs: a two-bit port-size acknowledge, an active-low error line and an active-low halt line. It settles each cycle as a normal completion, a bus error or a retry. It then releases the strobe for one clock and reports the outcome on a single-clock done strobe.

An error line that asserts in the clock after the acknowledge still overrides that acknowledge, and the captured data is then flagged as not valid. Error and halt asserted together request a retry. After a retry the block waits for halt to negate and then launches the same address, size and cycle kind again, with no new request. A bus-error outcome raises one of two exception flags. Instruction-fetch cycles get the deferred flag, because the fetched word may never be executed. Data cycles get the immediate flag.

Top module: `cyc_term_ctrl`

## Requirements
- R1: With a nonzero acknowledge code (01 = 8-bit port, 10 = 16-bit, 11 = 32-bit; 00 = no acknowledge) and no effective error in the first sample or the following window sample, the cycle ends normal. `data_o` holds the data present at the acknowledge sample, `ack_size_o` holds that code, and `data_valid_o` is 1 during done. While no acknowledge, error or retry condition is seen, the cycle stays open with the strobe asserted.
- R2: An effective error with no acknowledge and halt negated ends the cycle as a bus error.
- R3: After an acknowledge accepted with error negated, an effective error in the next clock's sample with halt negated ends the cycle as a bus error, overriding the acknowledge.
- R4: An effective error together with halt asserted, in the first sample or in the window sample, ends the cycle as a retry.
- R5: An error sampled together with an acknowledge wins over it. A bus-error outcome always reports `data_valid_o` = 0.
- R6: After the deciding sample the strobe `as_o` is low for one clock with `done_o` low. Then `done_o` is high for exactly one clock.
- R7: `outcome_o` reads 00 for normal, 01 for bus error and 10 for retry, and is valid while `done_o` is high.
- R8: On a bus-error outcome, `exc_defer_o` pulses with done when the cycle was launched with `fetch_i` = 1, and `exc_now_o` pulses otherwise. Neither flag is set outside such a done.
- R9: An error line already asserted at a launch edge is ignored until it has been sampled negated once within that cycle.
- R10: After a retry the block stays busy (`ready_o` = 0, strobe low) while halt is asserted. It relaunches the same `cyc_addr_o` and `cyc_size_o` at the first edge that sees halt negated.
- R11: A request is taken only when `ready_o` is 1. A request while busy does not change `cyc_addr_o`.
- R12: After reset `ready_o` = 1, `as_o` = 0 and `done_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Cycle request, taken when ready |
| fetch_i | input | 1 | Request is an instruction fetch |
| addr_i | input | AW | Request address |
| size_i | input | 2 | Request transfer size |
| ready_o | output | 1 | Idle, request accepted |
| as_o | output | 1 | Address strobe, cycle open |
| cyc_addr_o | output | AW | Address of the running cycle |
| cyc_size_o | output | 2 | Size of the running cycle |
| ack_i | input | 2 | Port-size acknowledge, 00 = none |
| berr_n_i | input | 1 | Bus error, active low |
| halt_n_i | input | 1 | Halt, active low |
| data_i | input | DW | Read data from the bus |
| done_o | output | 1 | One-clock outcome strobe |
| outcome_o | output | 2 | Outcome code |
| ack_size_o | output | 2 | Acknowledge code of the completed cycle |
| data_o | output | DW | Data captured at acknowledge |
| data_valid_o | output | 1 | Data usable, normal completion |
| exc_now_o | output | 1 | Raise the bus-error exception now |
| exc_defer_o | output | 1 | Bus-error exception deferred |

## Verification
The assertions check the following on every cycle:
- the one-clock strobe release after each decision, and the single-clock done;
- the masking of an error level carried over a launch edge;
- that a late error, or error together with halt, leads to the right code two clocks on;
- that the address stays fixed across a retry wait.

Only the bench's sweep can show the mapping from patterns to outcomes. That sweep covers every acknowledge code, error and halt combination in the first sample and the window sample, each with and without a stale error. It also shows the captured data and size, the fetch-dependent exception flag, and the relaunch once halt clears.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  typedef enum logic [1:0] {
    OUT_NORMAL = 2'b00,
    OUT_BERR   = 2'b01,
    OUT_RETRY  = 2'b10
  } outcome_e;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_ACK,
    EV_BERR,
    EV_RETRY
  } term_ev_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_LATE,
    ST_TERM,
    ST_REPORT,
    ST_RWAIT
  } bus_st_e;

  // Decision taken on the first sample of an open cycle.
  function automatic term_ev_e first_sample_ev(logic ack_seen, logic err, logic hlt);
    if (err && hlt) return EV_RETRY;
    if (err)        return EV_BERR;
    if (ack_seen)   return EV_ACK;
    return EV_NONE;
  endfunction

  // Decision taken in the clock after an accepted acknowledge.
  function automatic outcome_e window_outcome(logic err, logic hlt);
    if (err && hlt) return OUT_RETRY;
    if (err)        return OUT_BERR;
    return OUT_NORMAL;
  endfunction

endpackage

// File: rtl/cbt_sampler.sv
module cbt_sampler #(
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic [ACK_W-1:0] ack_i,
  input  logic             berr_n_i,
  input  logic             halt_n_i,
  output logic             ack_seen_o,
  output logic             err_o,
  output logic             hlt_o
);

  // armed is cleared when the error line is low at a launch edge and set
  // again once it is seen high.
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b1;
    else if (launch_i) armed <= berr_n_i;
    else if (berr_n_i) armed <= 1'b1;
  end

  assign ack_seen_o = |ack_i;
  assign err_o      = !berr_n_i && armed;
  assign hlt_o      = !halt_n_i;

  // R9: an error level carried over a launch edge is not taken next clock
  assert_stale_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_i && !berr_n_i) |=> (berr_n_i || !err_o));

endmodule

// File: rtl/cbt_fsm.sv
module cbt_fsm
  import cbt_pkg::*;
#(
  parameter int AW   = 16,
  parameter int SZ_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            fetch_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic            ack_seen_i,
  input  logic            err_i,
  input  logic            hlt_i,
  input  outcome_e        outcome_q_i,
  output logic            ready_o,
  output logic            as_o,
  output logic            launch_o,
  output logic            dec_valid_o,
  output outcome_e        dec_outcome_o,
  output logic            capture_o,
  output logic            report_o,
  output logic            in_late_o,
  output logic [AW-1:0]   addr_o,
  output logic [SZ_W-1:0] size_o,
  output logic            fetch_o
);

  bus_st_e  st, st_nx;
  term_ev_e ev;
  logic     take_start, relaunch;

  assign ev         = first_sample_ev(ack_seen_i, err_i, hlt_i);
  assign take_start = (st == ST_IDLE) && start_i;
  assign relaunch   = (st == ST_RWAIT) && !hlt_i;
  assign launch_o   = take_start || relaunch;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (start_i) st_nx = ST_ACTIVE;
      ST_ACTIVE: begin
        if (ev == EV_ACK)                         st_nx = ST_LATE;
        else if (ev == EV_BERR || ev == EV_RETRY) st_nx = ST_TERM;
      end
      ST_LATE:   st_nx = ST_TERM;
      ST_TERM:   st_nx = ST_REPORT;
      ST_REPORT: st_nx = (outcome_q_i == OUT_RETRY) ? ST_RWAIT : ST_IDLE;
      ST_RWAIT:  if (!hlt_i) st_nx = ST_ACTIVE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o  <= '0;
      size_o  <= '0;
      fetch_o <= 1'b0;
    end else if (take_start) begin
      addr_o  <= addr_i;
      size_o  <= size_i;
      fetch_o <= fetch_i;
    end
  end

  assign dec_valid_o = ((st == ST_ACTIVE) && (ev == EV_BERR || ev == EV_RETRY))
                       || (st == ST_LATE);

  always_comb begin
    if (st == ST_LATE)       dec_outcome_o = window_outcome(err_i, hlt_i);
    else if (ev == EV_RETRY) dec_outcome_o = OUT_RETRY;
    else                     dec_outcome_o = OUT_BERR;
  end

  assign capture_o = (st == ST_ACTIVE) && (ev == EV_ACK);
  assign ready_o   = (st == ST_IDLE);
  assign as_o      = (st == ST_ACTIVE) || (st == ST_LATE);
  assign report_o  = (st == ST_REPORT);
  assign in_late_o = (st == ST_LATE);

  // R6: strobe released and no report in the clock after a decision
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |=> (!as_o && !report_o));

  // R6: the report follows the release clock
  assert_report_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |=> ##1 report_o);

  // R6: the report lasts one clock
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    report_o |=> !report_o);

  // R10, R11: cycle address fixed for as long as the block is busy
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && $past(!ready_o)) |-> $stable(addr_o));

endmodule

// File: rtl/cbt_report.sv
module cbt_report
  import cbt_pkg::*;
#(
  parameter int DW    = 32,
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             capture_i,
  input  logic [ACK_W-1:0] ack_i,
  input  logic [DW-1:0]    data_i,
  input  logic             dec_valid_i,
  input  outcome_e         dec_outcome_i,
  input  logic             report_i,
  input  logic             fetch_i,
  output outcome_e         outcome_q_o,
  output logic             done_o,
  output logic [ACK_W-1:0] ack_size_o,
  output logic [DW-1:0]    data_o,
  output logic             data_valid_o,
  output logic             exc_now_o,
  output logic             exc_defer_o
);

  logic is_berr;

  always_ff @(posedge clk) begin
    if (!rst_n)           outcome_q_o <= OUT_NORMAL;
    else if (dec_valid_i) outcome_q_o <= dec_outcome_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_size_o <= '0;
      data_o     <= '0;
    end else if (launch_i) begin
      ack_size_o <= '0;
    end else if (capture_i) begin
      ack_size_o <= ack_i;
      data_o     <= data_i;
    end
  end

  assign is_berr      = (outcome_q_o == OUT_BERR);
  assign done_o       = report_i;
  assign data_valid_o = report_i && (outcome_q_o == OUT_NORMAL);
  assign exc_now_o    = report_i && is_berr && !fetch_i;
  assign exc_defer_o  = report_i && is_berr && fetch_i;

endmodule

// File: rtl/cyc_term_ctrl.sv
module cyc_term_ctrl
  import cbt_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int SZ_W  = 2,
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             fetch_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [SZ_W-1:0]  size_i,
  output logic             ready_o,
  output logic             as_o,
  output logic [AW-1:0]    cyc_addr_o,
  output logic [SZ_W-1:0]  cyc_size_o,
  input  logic [ACK_W-1:0] ack_i,
  input  logic             berr_n_i,
  input  logic             halt_n_i,
  input  logic [DW-1:0]    data_i,
  output logic             done_o,
  output logic [1:0]       outcome_o,
  output logic [ACK_W-1:0] ack_size_o,
  output logic [DW-1:0]    data_o,
  output logic             data_valid_o,
  output logic             exc_now_o,
  output logic             exc_defer_o
);

  logic     launch, ack_seen, err, hlt;
  logic     dec_valid, capture, report, in_late, fetch_q;
  outcome_e dec_outcome, outcome_q;

  cbt_sampler #(.ACK_W(ACK_W)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_i   (launch),
    .ack_i      (ack_i),
    .berr_n_i   (berr_n_i),
    .halt_n_i   (halt_n_i),
    .ack_seen_o (ack_seen),
    .err_o      (err),
    .hlt_o      (hlt)
  );

  cbt_fsm #(.AW(AW), .SZ_W(SZ_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .fetch_i       (fetch_i),
    .addr_i        (addr_i),
    .size_i        (size_i),
    .ack_seen_i    (ack_seen),
    .err_i         (err),
    .hlt_i         (hlt),
    .outcome_q_i   (outcome_q),
    .ready_o       (ready_o),
    .as_o          (as_o),
    .launch_o      (launch),
    .dec_valid_o   (dec_valid),
    .dec_outcome_o (dec_outcome),
    .capture_o     (capture),
    .report_o      (report),
    .in_late_o     (in_late),
    .addr_o        (cyc_addr_o),
    .size_o        (cyc_size_o),
    .fetch_o       (fetch_q)
  );

  cbt_report #(.DW(DW), .ACK_W(ACK_W)) u_report (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch_i      (launch),
    .capture_i     (capture),
    .ack_i         (ack_i),
    .data_i        (data_i),
    .dec_valid_i   (dec_valid),
    .dec_outcome_i (dec_outcome),
    .report_i      (report),
    .fetch_i       (fetch_q),
    .outcome_q_o   (outcome_q),
    .done_o        (done_o),
    .ack_size_o    (ack_size_o),
    .data_o        (data_o),
    .data_valid_o  (data_valid_o),
    .exc_now_o     (exc_now_o),
    .exc_defer_o   (exc_defer_o)
  );

  assign outcome_o = outcome_q;

  // R3: a window error with halt negated is reported as a bus error
  assert_late_berr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_late && err && !hlt) |=> ##1 (done_o && outcome_o == 2'b01));

  // R4: error with halt is reported as a retry
  assert_retry_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && err && hlt) |=> ##1 (done_o && outcome_o == 2'b10));

  // R5, R8: a bus-error decision yields invalid data and one exception flag
  assert_berr_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_outcome == OUT_BERR) |=> ##1
      (done_o && !data_valid_o && (exc_now_o != exc_defer_o)));

  // R10: the block stays busy after a retry report
  assert_retry_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && outcome_o == 2'b10) |=> (!ready_o && !done_o));

endmodule

// File: tb/cyc_term_ctrl_test.sv
module cyc_term_ctrl_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n, start_i, fetch_i, berr_n_i, halt_n_i;
  logic [15:0] addr_i;
  logic [1:0]  size_i, ack_i;
  logic [31:0] data_i;
  logic        ready_o, as_o, done_o, data_valid_o, exc_now_o, exc_defer_o;
  logic [15:0] cyc_addr_o;
  logic [1:0]  cyc_size_o, outcome_o, ack_size_o;
  logic [31:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  cyc_term_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fetch_i(fetch_i),
    .addr_i(addr_i), .size_i(size_i), .ready_o(ready_o), .as_o(as_o),
    .cyc_addr_o(cyc_addr_o), .cyc_size_o(cyc_size_o), .ack_i(ack_i),
    .berr_n_i(berr_n_i), .halt_n_i(halt_n_i), .data_i(data_i),
    .done_o(done_o), .outcome_o(outcome_o), .ack_size_o(ack_size_o),
    .data_o(data_o), .data_valid_o(data_valid_o), .exc_now_o(exc_now_o),
    .exc_defer_o(exc_defer_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // 0 none, 1 acknowledge, 2 bus error, 3 retry
  function automatic int first_kind(logic [1:0] a, bit e, bit h);
    if (e && h) return 3;
    if (e) return 2;
    if (a != 2'b00) return 1;
    return 0;
  endfunction

  task automatic run_case(input bit fetch, input logic [15:0] addr,
                          input logic [1:0] a0, input bit b0, input bit h0,
                          input bit b1, input bit h1, input bit stale);
    bit armed, eff;
    int kind, res;
    logic [1:0]  a_cap;
    logic [31:0] d_exp;
    armed = !stale;
    @(negedge clk);
    start_i = 1; fetch_i = fetch; addr_i = addr; size_i = a0 ^ 2'b01;
    berr_n_i = !stale; halt_n_i = 1; ack_i = 0;
    @(negedge clk);
    chk(as_o && !ready_o, "R11 launch", {as_o, ready_o}, 2'b10);
    addr_i = ~addr;
    ack_i = a0; berr_n_i = !b0; halt_n_i = !h0;
    d_exp = {addr, ~addr} ^ {30'd0, a0};
    data_i = d_exp;
    a_cap = a0;
    eff = b0 && armed;
    if (!b0) armed = 1;
    kind = first_kind(a0, eff, h0);
    if (kind == 0) begin
      @(negedge clk);
      chk(as_o && !done_o, "R1 wait", {as_o, done_o}, 2'b10);
      ack_i = 2'b01; berr_n_i = 1; halt_n_i = 1; armed = 1;
      a_cap = 2'b01; kind = 1;
    end
    @(negedge clk);
    start_i = 0; addr_i = addr;
    chk(cyc_addr_o == addr, "R11 busy request ignored", cyc_addr_o, addr);
    if (kind == 1) begin
      chk(as_o == 1, "R1 window strobe", as_o, 1);
      ack_i = 0; berr_n_i = !b1; halt_n_i = !h1;
      eff = b1 && armed;
      res = (eff && h1) ? 2 : (eff ? 1 : 0);
      @(negedge clk);
    end else begin
      res = (kind == 3) ? 2 : 1;
    end
    chk(!as_o && !done_o, "R6 release", {as_o, done_o}, 2'b00);
    ack_i = 0; berr_n_i = 1; halt_n_i = (res == 2) ? 0 : 1;
    @(negedge clk);
    chk(done_o == 1, "R6 done", done_o, 1);
    chk(outcome_o == res[1:0], "R7 R2 R3 R4 outcome", outcome_o, res);
    chk(data_valid_o == (res == 0), "R5 data valid", data_valid_o, res == 0);
    if (res == 0) begin
      chk(data_o == d_exp, "R1 data", data_o, d_exp);
      chk(ack_size_o == a_cap, "R1 ack size", ack_size_o, a_cap);
    end
    chk(exc_now_o == (res == 1 && !fetch), "R8 now", exc_now_o, res == 1 && !fetch);
    chk(exc_defer_o == (res == 1 && fetch), "R8 defer", exc_defer_o, res == 1 && fetch);
    @(negedge clk);
    chk(done_o == 0 && !exc_now_o && !exc_defer_o, "R6 single done",
        {done_o, exc_now_o, exc_defer_o}, 0);
    if (res == 2) begin
      chk(!ready_o && !as_o, "R10 hold", {ready_o, as_o}, 0);
      @(negedge clk);
      chk(!ready_o && !as_o, "R10 hold 2", {ready_o, as_o}, 0);
      halt_n_i = 1;
      @(negedge clk);
      chk(as_o && cyc_addr_o == addr && cyc_size_o == (a0 ^ 2'b01),
          "R10 relaunch", {as_o, cyc_addr_o, cyc_size_o}, {1'b1, addr, a0 ^ 2'b01});
      ack_i = 2'b10; data_i = ~d_exp;
      @(negedge clk);
      ack_i = 0;
      @(negedge clk);
      @(negedge clk);
      chk(done_o && outcome_o == 2'b00 && ack_size_o == 2'b10 && data_o == ~d_exp,
          "R10 retried cycle", {done_o, outcome_o, ack_size_o}, {1'b1, 2'b00, 2'b10});
      @(negedge clk);
    end
    chk(ready_o == 1, "R11 idle again", ready_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; fetch_i = 0; addr_i = 0; size_i = 0;
    ack_i = 0; berr_n_i = 1; halt_n_i = 1; data_i = 0;
    repeat (3) @(negedge clk);
    chk(ready_o && !as_o && !done_o, "R12 reset", {ready_o, as_o, done_o}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(ready_o && !as_o && !done_o, "R12 after reset", {ready_o, as_o, done_o}, 3'b100);
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 4; a++)
        for (int p = 0; p < 16; p++)
          run_case(p[0] ^ s[0], 16'(16'h1357 + 97 * (s * 64 + a * 16 + p)),
                   2'(a), p[3], p[2], p[1], p[0], s[0]);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule